// File: doc/BRIEF.md
# Aligned Circular Trace Store

The block captures 64-bit trace records into a 64-line ring while a debug session is armed. It stops, extends or starts capture around a trigger according to an alignment mode. In the trailing mode, capture begins when the sequencer reports that its first active state has been entered, and the trigger closes the session. In the centred mode, capture also begins at that entry, and the trigger is followed by exactly 32 more stored lines. In the leading mode, capture begins with the record present at the trigger and continues until 64 lines are held.

Records come from two sources, a main CPU and a coprocessor. While the main CPU is halted for background debugging, records from the CPU are dropped and records from the coprocessor are still taken. Once the session has ended, software unloads the ring through a 16-bit read window, one quarter-line at a time, starting from the oldest line. A single-cycle completion pulse marks the end of each session.

Top module: `trace_ring`

## Requirements
- R1: Storage is 64 lines of 64 bits, written in ring order. From the 65th stored line of a session onward, each new line overwrites the oldest line.
- R2: `cnt_o` counts the lines stored in the current session. It rises by one on each stored line, saturates at 64, reads 0 after reset and is cleared by `arm_i`.
- R3: A read returns on `rd_data_o` in the cycle after `rd_i`. Word select 0 returns bits 15:0, 1 returns bits 31:16, 2 returns bits 47:32 and 3 returns bits 63:48. The read position moves to the next line only once each of the four words of the current line has been read. Repeating a word does not advance it.
- R4: A read issued while a session is armed returns all zeros.
- R5: In trailing mode and in centred mode, no record is stored before a `seq_start_i` pulse seen while armed. Storing starts in the cycle after that pulse.
- R6: In trailing mode, a trigger ends the session. The record presented in the trigger cycle is stored if it is accepted, and later records are not stored.
- R7: In centred mode, the line stored in the trigger cycle is followed by exactly 32 further stored lines, and then the session ends.
- R8: In leading mode, nothing is stored before the trigger. The record presented with the trigger is the first stored line, and the session ends when the 64th line is stored.
- R9: A record with `rec_cop_i`=0 (main CPU) is dropped while `halt_dbg_i`=1. A record with `rec_cop_i`=1 (coprocessor) is stored regardless of `halt_dbg_i`.
- R10: `done_o` is a one-cycle pulse in the cycle after the end condition is met. The session is disarmed in that same cycle.
- R11: After a session ends, reading starts at the oldest stored line. That is line 0 of the session if fewer than 64 lines were stored, and otherwise the line written 64 stores before the end.
- R12: `align_i` is sampled only at `arm_i`. The encodings are 00 = trailing, 01 = centred, 10 = leading and 11 = trailing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Pulse that arms a new session |
| seq_start_i | input | 1 | Pulse marking entry to the sequencer's first active state |
| trig_i | input | 1 | Trigger pulse from the sequencer |
| align_i | input | 2 | Alignment mode, sampled at arm |
| rec_i | input | 64 | Trace record |
| rec_vld_i | input | 1 | Record valid strobe |
| rec_cop_i | input | 1 | Record source: 1 = coprocessor, 0 = main CPU |
| halt_dbg_i | input | 1 | Main CPU is in background debug |
| rd_i | input | 1 | Read strobe |
| rd_word_i | input | 2 | Word of the current line to read |
| rd_data_o | output | 16 | Read data, valid the cycle after `rd_i` |
| cnt_o | output | 7 | Stored-line count |
| done_o | output | 1 | Session-complete pulse |

## Verification
The trigger and a record capture can land in the same cycle. The outcome then depends on the mode: the trigger record is kept in trailing and leading modes, it is not counted among the 32 trailing lines in centred mode, and it is dropped when the record is a main CPU record during halt. The bench drives the record, its source, the halt flag and `trig_i` together on one edge. It judges the result by the completion pulse and count one cycle later, and by unloading the ring and comparing each line with a record sequence computed in the bench.

// File: rtl/trace_ring.sv
module trace_ring #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 64,
  parameter int RDW   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_i,
  input  logic                        seq_start_i,
  input  logic                        trig_i,
  input  logic [1:0]                  align_i,
  input  logic [WIDTH-1:0]            rec_i,
  input  logic                        rec_vld_i,
  input  logic                        rec_cop_i,
  input  logic                        halt_dbg_i,
  input  logic                        rd_i,
  input  logic [$clog2(WIDTH/RDW)-1:0] rd_word_i,
  output logic [RDW-1:0]              rd_data_o,
  output logic [$clog2(DEPTH):0]      cnt_o,
  output logic                        done_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = AW + 1;
  localparam int NW   = WIDTH / RDW;
  localparam int HALF = DEPTH / 2;
  localparam logic [1:0] M_MID   = 2'b01;
  localparam logic [1:0] M_BEGIN = 2'b10;

  logic [WIDTH-1:0] mem [DEPTH];
  logic             armed, storing, trigd;
  logic [1:0]       mode;
  logic [AW-1:0]    wptr, roff, post, base, raddr;
  logic [CW-1:0]    cnt;
  logic [NW-1:0]    seen, seen_n;
  logic [WIDTH-1:0] rline;
  logic             is_begin, is_mid, is_end, accept, live, cap, fin;

  assign is_begin = (mode == M_BEGIN);
  assign is_mid   = (mode == M_MID);
  assign is_end   = !is_begin && !is_mid;
  assign accept   = rec_vld_i && (rec_cop_i || !halt_dbg_i);
  assign live     = armed && !arm_i;
  assign cap      = live && accept && (storing || (is_begin && trig_i));
  assign fin      = live && ((is_end && trig_i)
                    || (is_mid && trigd && cap && post == AW'(HALF - 1))
                    || (is_begin && cap && cnt == CW'(DEPTH - 1)));

  always_ff @(posedge clk) begin
    if (cap) mem[wptr] <= rec_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      storing <= 1'b0;
      trigd   <= 1'b0;
      mode    <= 2'b00;
      post    <= '0;
      cnt     <= '0;
      wptr    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= fin;
      if (arm_i) begin
        armed   <= 1'b1;
        storing <= 1'b0;
        trigd   <= 1'b0;
        mode    <= align_i;
        post    <= '0;
        cnt     <= '0;
        wptr    <= '0;
      end else if (armed) begin
        if (cap) begin
          wptr <= wptr + 1'b1;
          if (cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
        end
        if (seq_start_i && !is_begin) storing <= 1'b1;
        if (trig_i && is_begin) storing <= 1'b1;
        if (trig_i && is_mid) trigd <= 1'b1;
        if (trigd && cap) post <= post + 1'b1;
        if (fin) begin
          armed   <= 1'b0;
          storing <= 1'b0;
        end
      end
    end
  end

  assign base   = (cnt == CW'(DEPTH)) ? wptr : '0;
  assign raddr  = base + roff;
  assign rline  = mem[raddr];
  assign seen_n = seen | (NW'(1) << rd_word_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      roff      <= '0;
      seen      <= '0;
      rd_data_o <= '0;
    end else begin
      if (fin) begin
        roff <= '0;
        seen <= '0;
      end else if (rd_i && !armed) begin
        if (&seen_n) begin
          roff <= roff + 1'b1;
          seen <= '0;
        end else begin
          seen <= seen_n;
        end
      end
      if (rd_i) rd_data_o <= armed ? '0 : rline[rd_word_i*RDW +: RDW];
    end
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/trace_ring_chk.sv
module trace_ring_chk #(
  parameter int DEPTH = 64,
  parameter int RDW   = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   arm_i,
  input logic                   rd_i,
  input logic                   armed,
  input logic                   done_o,
  input logic [$clog2(DEPTH):0] cnt_o,
  input logic [RDW-1:0]         rd_data_o
);
  localparam int CW = $clog2(DEPTH) + 1;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_o <= CW'(DEPTH)); // R2
  AST_ARM_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n) arm_i |=> cnt_o == '0); // R2
  AST_IDLE_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!armed && !arm_i) |=> $stable(cnt_o)); // R2
  AST_ARMED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_i && armed) |=> rd_data_o == '0); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R10
  AST_DONE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !armed); // R10
endmodule

bind trace_ring trace_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .rd_i(rd_i), .armed(armed),
  .done_o(done_o), .cnt_o(cnt_o), .rd_data_o(rd_data_o)
);

// File: tb/trace_ring_tb.sv
`timescale 1ns/1ps
module trace_ring_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        arm_i = 0, seq_start_i = 0, trig_i = 0, rec_vld_i = 0, rec_cop_i = 0, halt_dbg_i = 0, rd_i = 0;
  logic [1:0]  align_i = 0, rd_word_i = 0;
  logic [63:0] rec_i = 0;
  logic [15:0] rd_data_o;
  logic [6:0]  cnt_o;
  logic        done_o;

  trace_ring u_dut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .seq_start_i(seq_start_i), .trig_i(trig_i),
    .align_i(align_i), .rec_i(rec_i), .rec_vld_i(rec_vld_i), .rec_cop_i(rec_cop_i),
    .halt_dbg_i(halt_dbg_i), .rd_i(rd_i), .rd_word_i(rd_word_i), .rd_data_o(rd_data_o),
    .cnt_o(cnt_o), .done_o(done_o)
  );

  always #2 clk = ~clk;

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [63:0] exp_q [256];
  int m_n, m_post;
  bit m_armed, m_storing, m_trigd;
  logic [1:0] m_mode;

  function automatic logic [63:0] mk(int k);
    return {16'(k * 7 + 3), 16'(k ^ 'h5A5A), 16'(k + 'h1000), 16'(k)};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_arm(logic [1:0] m);
    @(negedge clk); arm_i = 1; align_i = m;
    @(negedge clk); arm_i = 0;
    m_mode = m; m_armed = 1; m_storing = 0; m_trigd = 0; m_post = 0; m_n = 0;
    chk("R2 cleared on arm", 64'(cnt_o), 0);
  endtask

  task automatic do_start();
    @(negedge clk); seq_start_i = 1;
    @(negedge clk); seq_start_i = 0;
    if (m_armed && m_mode != 2'b10) m_storing = 1;
  endtask

  task automatic send(string tag, int k, bit cop, bit hb, bit trg);
    bit acc, cap, endc;
    @(negedge clk);
    rec_i = mk(k); rec_vld_i = 1; rec_cop_i = cop; halt_dbg_i = hb; trig_i = trg;
    acc  = cop || !hb;
    cap  = m_armed && acc && (m_storing || (m_mode == 2'b10 && trg));
    endc = 0;
    if (cap) begin exp_q[m_n] = mk(k); m_n++; end
    if (m_armed && m_trigd && cap) m_post++;
    if (m_armed) begin
      if ((m_mode == 2'b00 || m_mode == 2'b11) && trg) endc = 1;
      if (m_mode == 2'b01 && m_trigd && cap && m_post == 32) endc = 1;
      if (m_mode == 2'b10 && cap && m_n == 64) endc = 1;
      if (trg && m_mode == 2'b01) m_trigd = 1;
      if (trg && m_mode == 2'b10) m_storing = 1;
    end
    if (endc) m_armed = 0;
    @(negedge clk);
    rec_vld_i = 0; trig_i = 0; halt_dbg_i = 0; rec_cop_i = 0;
    chk({tag, " R10 done"}, 64'(done_o), 64'(endc));
    chk({tag, " R2 count"}, 64'(cnt_o), 64'(m_n > 64 ? 64 : m_n));
  endtask

  task automatic rd_word(string tag, int w, logic [15:0] exp);
    @(negedge clk); rd_i = 1; rd_word_i = 2'(w);
    @(negedge clk); rd_i = 0;
    chk(tag, 64'(rd_data_o), 64'(exp));
  endtask

  task automatic rd_line(string tag, logic [63:0] e);
    for (int w = 0; w < 4; w++) rd_word(tag, w, e[16*w +: 16]);
  endtask

  task automatic unload(string tag);
    int first = (m_n > 64) ? m_n - 64 : 0;
    for (int i = first; i < m_n; i++) rd_line(tag, exp_q[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++; nvec++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    m_armed = 0; m_storing = 0; m_trigd = 0; m_n = 0; m_post = 0; m_mode = 0;
    repeat (3) @(negedge clk);
    chk("R2 reset count", 64'(cnt_o), 0);
    chk("R10 reset done", 64'(done_o), 0);
    rst_n = 1;

    // trailing mode, partial-line read ordering
    do_arm(2'b00);
    for (int k = 1; k <= 3; k++) send("R5 before start", k, 0, 0, 0);
    do_start();
    for (int k = 10; k < 20; k++) send("R1 trailing", k, 0, 0, 0);
    send("R6 trigger line", 20, 0, 0, 1);
    send("R6 after end", 99, 1, 0, 0);
    rd_word("R3 w0", 0, mk(10)[15:0]);
    rd_word("R3 w1", 1, mk(10)[31:16]);
    rd_word("R3 w2", 2, mk(10)[47:32]);
    rd_word("R3 repeat holds line", 0, mk(10)[15:0]);
    rd_word("R3 w3", 3, mk(10)[63:48]);
    rd_word("R3 advanced", 0, mk(11)[15:0]);
    rd_word("R3 w1", 1, mk(11)[31:16]);
    rd_word("R3 w2", 2, mk(11)[47:32]);
    rd_word("R3 w3", 3, mk(11)[63:48]);
    for (int i = 2; i < m_n; i++) rd_line("R11 trailing order", exp_q[i]);

    // centred mode with wrap and halt filtering
    do_arm(2'b01);
    rd_word("R4 armed read", 0, 16'h0);
    send("R5 before start", 200, 0, 0, 0);
    send("R5 before start", 201, 1, 0, 0);
    do_start();
    for (int k = 300; k < 350; k++) send("R1 centred", k, 0, 0, 0);
    send("R7 trigger", 350, 0, 0, 1);
    for (int j = 0; j < 40 && m_armed; j++)
      send("R7 R9 post", 400 + j, (j % 3) != 0, (j % 2) == 0, 0);
    chk("R7 ended", 64'(m_armed), 0);
    send("R7 after end", 999, 1, 0, 0);
    unload("R11 centred wrap");

    // leading mode, alignment changed after arm
    do_arm(2'b10);
    align_i = 2'b00;
    do_start();
    for (int k = 500; k < 505; k++) send("R8 before trigger", k, 0, 0, 0);
    send("R8 trigger first", 600, 0, 0, 1);
    for (int k = 601; k < 664; k++) send("R8 R12 leading", k, 1, 1, 0);
    chk("R8 ended", 64'(m_armed), 0);
    rd_line("R8 first line", mk(600));
    for (int i = 1; i < 64; i++) rd_line("R11 leading order", exp_q[i]);

    // mode 11 behaves as trailing, suppressed trigger record
    do_arm(2'b11);
    do_start();
    send("R12 mode3", 700, 0, 0, 0);
    send("R9 cop during halt", 701, 1, 1, 0);
    send("R9 R12 cpu trigger in halt", 702, 0, 1, 1);
    unload("R9 contents");

    do_arm(2'b00);
    send("R5 not started", 800, 0, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule